// File: doc/BRIEF.md
# Colour LUT Indirect Programming Register Bank

This block is the CPU side of a three-dimensional colour lookup table that is split across several sub-RAMs. It decodes a word-addressed 32-bit register bus with separate read and write strobes. It reports the build parameters of the table and holds a control word that turns the table on and selects which copy the pixel path uses. For each sub-RAM it also provides an indirect access window, through which software stages an entry in data registers and commits it with a self-clearing bit in the window's address register.

With double buffering built in, every sub-RAM holds two copies of the table. The CPU always writes, and reads back, the copy the pixel path is not using. A new buffer selection only reaches the pixel path on the cycle after a frame-start pulse, so a frame is never read from a half-written table. The pixel side gets one registered read port per sub-RAM, which always reads the active copy.

Top module: `lutcfg_regbank`

## Requirements
- R1: In reset, `lut_enable` is 0, `lut_active_buf` is 0, `bus_rvalid` is 0, `bus_rdata` is 0, and the control word reads 0.
- R2: Each cycle with `bus_rd` high makes `bus_rvalid` high on the next cycle, with the read word on `bus_rdata`. `bus_rvalid` is low after every cycle without `bus_rd`.
- R3: The parameter words are read-only. Word 0x03 gives pixels in parallel, 0x04 input bits per sample, 0x05 output bits per sample, 0x06 alpha channel count, 0x07 LUT bits per colour, 0x08 LUT size, 0x09 double-buffer present (1/0) and 0x0A read-back present (1/0).
- R4: The control word is at word address 0x52. Bit 0 is the enable and drives `lut_enable` from the cycle after the write. Bit 1 is the requested buffer. Bits 31:2 read 0. `lut_enable` changes only after a bus write.
- R5: With double buffering, `lut_active_buf` takes the requested buffer only on the cycle after a `frame_start` pulse, and holds its value in every other cycle.
- R6: Without double buffering, bit 1 of the control word reads 0 and `lut_active_buf` stays 0.
- R7: Sub-RAM n has a four-word window at word 0x60+4n. The address word is at +0, lower data at +2 and upper data at +3. In the address word, bits 16:0 hold the entry address, of which the low RAM_AW bits are kept and the rest read 0. Bit 28 commits, and it reads 0 once the commit is done.
- R8: A commit writes the staged entry (upper data bits above bit 31, lower data in bits 31:0) into the copy not in use by the pixel path (copy 0 without double buffering). The active copy is left unchanged.
- R9: The upper data word exists only when the entry width (alpha+3)*bits_per_colour exceeds 32. Otherwise it reads 0 and ignores writes.
- R10: With read-back built in, the data words return the CPU-side copy's entry at the window's stored address. Without read-back, they return the staged value.
- R11: Word addresses 0x00 to 0x02, 0x0B to 0x51, 0x53 to 0x5F, window offset +1 and windows beyond the last sub-RAM read 0 and ignore writes.
- R12: `pix_data` slice n gives, one cycle later, the active copy's entry at `pix_addr` slice n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| frame_start | input | 1 | Safe point for a buffer swap |
| lut_enable | output | 1 | LUT applied (1) or bypassed (0) |
| lut_active_buf | output | 1 | Copy in use by the pixel path |
| pix_addr | input | N_RAM*RAM_AW | Pixel-side entry address per sub-RAM |
| pix_data | output | N_RAM*EW | Pixel-side entry per sub-RAM, registered |

## Verification
The assertions check the following on every cycle: the read handshake timing, that the active buffer moves only after a frame-start pulse, that the enable moves only after a bus write, that a single-buffered build stays on buffer 0, and that reserved words and reserved control bits read zero. Only the bench scenarios can show the following: that a commit lands in the inactive copy and leaves the active copy unchanged, that read-back returns RAM contents rather than the staged value, that the upper word vanishes on a narrow build, and that a swap then shows the freshly written entry to the pixel port.

// File: rtl/lutcfg_pkg.sv
package lutcfg_pkg;

    localparam int BUS_AW = 8;

    localparam logic [BUS_AW-1:0] WA_PARAM_FIRST = 8'h03;
    localparam logic [BUS_AW-1:0] WA_PARAM_LAST  = 8'h0A;
    localparam logic [BUS_AW-1:0] WA_CTRL        = 8'h52;
    localparam logic [BUS_AW-1:0] WA_WIN_BASE    = 8'h60;
    localparam int               CMT_BIT        = 28;

    typedef enum logic [1:0] {
        SLOT_ADDR = 2'd0,
        SLOT_RSVD = 2'd1,
        SLOT_LO   = 2'd2,
        SLOT_HI   = 2'd3
    } win_slot_e;

    typedef struct packed {
        logic      hit_param;
        logic      hit_ctrl;
        logic      hit_win;
        logic [5:0] ram;
        win_slot_e slot;
    } dec_t;

    function automatic dec_t decode_addr(logic [BUS_AW-1:0] a, int n_ram);
        dec_t d;
        logic [BUS_AW-1:0] off;
        d = '0;
        off = a - WA_WIN_BASE;
        d.hit_param = (a >= WA_PARAM_FIRST) && (a <= WA_PARAM_LAST);
        d.hit_ctrl  = (a == WA_CTRL);
        if ((a >= WA_WIN_BASE) && (int'(off[BUS_AW-1:2]) < n_ram)) begin
            d.hit_win = 1'b1;
            d.ram     = off[BUS_AW-1:2];
            d.slot    = win_slot_e'(off[1:0]);
        end
        return d;
    endfunction

endpackage

// File: rtl/lutcfg_ram.sv
module lutcfg_ram #(
    parameter int AW     = 6,
    parameter int EW     = 40,
    parameter int COPIES = 2
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wr_copy,
    input  logic [AW-1:0] wr_addr,
    input  logic [EW-1:0] wr_data,
    input  logic          cpu_copy,
    input  logic [AW-1:0] cpu_addr,
    output logic [EW-1:0] cpu_q,
    input  logic          pix_copy,
    input  logic [AW-1:0] pix_addr,
    output logic [EW-1:0] pix_q
);
    localparam int IW    = (COPIES > 1) ? AW + 1 : AW;
    localparam int WORDS = 2 ** IW;

    logic [EW-1:0] mem [WORDS];
    logic [IW-1:0] w_idx, c_idx, p_idx;

    generate
        if (COPIES > 1) begin : g_two
            assign w_idx = {wr_copy, wr_addr};
            assign c_idx = {cpu_copy, cpu_addr};
            assign p_idx = {pix_copy, pix_addr};
        end else begin : g_one
            logic unused_copy;
            assign unused_copy = ^{wr_copy, cpu_copy, pix_copy};
            assign w_idx = wr_addr;
            assign c_idx = cpu_addr;
            assign p_idx = pix_addr;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (we) mem[w_idx] <= wr_data;
        pix_q <= mem[p_idx];
    end

    assign cpu_q = mem[c_idx];
endmodule

// File: rtl/lutcfg_window.sv
module lutcfg_window
    import lutcfg_pkg::*;
#(
    parameter int AW       = 6,
    parameter int EW       = 40,
    parameter int READBACK = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_addr_w,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [31:0]   wdata,
    input  win_slot_e     slot,
    input  logic [EW-1:0] cpu_q,
    output logic          commit,
    output logic [AW-1:0] entry_addr,
    output logic [EW-1:0] commit_data,
    output logic [31:0]   rd_word
);
    localparam int LW = (EW > 32) ? 32 : EW;

    logic [LW-1:0] stage_lo;
    logic [EW-1:0] stage, src;
    logic [31:0]   lo_word, hi_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            commit      <= 1'b0;
            entry_addr  <= '0;
            stage_lo    <= '0;
            commit_data <= '0;
        end else begin
            commit <= wr_addr_w & wdata[CMT_BIT];
            if (wr_addr_w) begin
                entry_addr  <= wdata[AW-1:0];
                commit_data <= stage;
            end
            if (wr_lo) stage_lo <= wdata[LW-1:0];
        end
    end

    assign src     = (READBACK != 0) ? cpu_q : stage;
    assign lo_word = 32'(src[LW-1:0]);

    generate
        if (EW > 32) begin : g_hi
            logic [EW-33:0] stage_hi;
            always_ff @(posedge clk) begin
                if (rst)        stage_hi <= '0;
                else if (wr_hi) stage_hi <= wdata[EW-33:0];
            end
            assign stage   = {stage_hi, stage_lo};
            assign hi_word = 32'(src[EW-1:32]);
        end else begin : g_nohi
            logic unused_hi;
            assign unused_hi = wr_hi;
            assign stage     = stage_lo;
            assign hi_word   = '0;
        end
    endgenerate

    always_comb begin
        case (slot)
            SLOT_ADDR: rd_word = 32'(entry_addr) | (32'(commit) << CMT_BIT);
            SLOT_LO:   rd_word = lo_word;
            SLOT_HI:   rd_word = hi_word;
            default:   rd_word = '0;
        endcase
    end
endmodule

// File: rtl/lutcfg_bufsel.sv
module lutcfg_bufsel #(
    parameter int DBUF = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_ctrl,
    input  logic [1:0]  wdata,
    input  logic        frame_start,
    output logic        enable,
    output logic        active,
    output logic [31:0] ctrl_word
);
    logic req;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            req    <= 1'b0;
            active <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                enable <= wdata[0];
                req    <= (DBUF != 0) & wdata[1];
            end
            if ((DBUF != 0) && frame_start) active <= req;
        end
    end

    assign ctrl_word = {30'b0, req, enable};
endmodule

// File: rtl/lutcfg_regbank.sv
module lutcfg_regbank
    import lutcfg_pkg::*;
#(
    parameter int N_RAM    = 8,
    parameter int RAM_AW   = 6,
    parameter int PIX_PAR  = 2,
    parameter int IN_BPS   = 10,
    parameter int OUT_BPS  = 12,
    parameter int ALPHA    = 1,
    parameter int BPC      = 10,
    parameter int LUT_DIM  = 17,
    parameter int DBUF     = 1,
    parameter int READBACK = 1,
    localparam int EW      = (ALPHA + 3) * BPC
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [BUS_AW-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_rvalid,
    input  logic                    frame_start,
    output logic                    lut_enable,
    output logic                    lut_active_buf,
    input  logic [N_RAM*RAM_AW-1:0] pix_addr,
    output logic [N_RAM*EW-1:0]     pix_data
);
    localparam int COPIES = (DBUF != 0) ? 2 : 1;

    dec_t        dec;
    logic [31:0] ctrl_word;
    logic [31:0] rd_next;
    logic [31:0] win_rd [N_RAM];
    logic        cpu_copy;

    assign dec      = decode_addr(bus_addr, N_RAM);
    assign cpu_copy = (DBUF != 0) ? ~lut_active_buf : 1'b0;

    lutcfg_bufsel #(.DBUF(DBUF)) u_bsel (
        .clk         (clk),
        .rst         (rst),
        .wr_ctrl     (bus_wr & dec.hit_ctrl),
        .wdata       (bus_wdata[1:0]),
        .frame_start (frame_start),
        .enable      (lut_enable),
        .active      (lut_active_buf),
        .ctrl_word   (ctrl_word)
    );

    generate
        for (genvar n = 0; n < N_RAM; n++) begin : g_ram
            logic              hit, commit;
            logic [RAM_AW-1:0] entry_addr;
            logic [EW-1:0]     commit_data, cpu_q;

            assign hit = bus_wr && dec.hit_win && (dec.ram == 6'(n));

            lutcfg_window #(.AW(RAM_AW), .EW(EW), .READBACK(READBACK)) u_win (
                .clk         (clk),
                .rst         (rst),
                .wr_addr_w   (hit && dec.slot == SLOT_ADDR),
                .wr_lo       (hit && dec.slot == SLOT_LO),
                .wr_hi       (hit && dec.slot == SLOT_HI),
                .wdata       (bus_wdata),
                .slot        (dec.slot),
                .cpu_q       (cpu_q),
                .commit      (commit),
                .entry_addr  (entry_addr),
                .commit_data (commit_data),
                .rd_word     (win_rd[n])
            );

            lutcfg_ram #(.AW(RAM_AW), .EW(EW), .COPIES(COPIES)) u_mem (
                .clk      (clk),
                .we       (commit),
                .wr_copy  (cpu_copy),
                .wr_addr  (entry_addr),
                .wr_data  (commit_data),
                .cpu_copy (cpu_copy),
                .cpu_addr (entry_addr),
                .cpu_q    (cpu_q),
                .pix_copy (lut_active_buf),
                .pix_addr (pix_addr[n*RAM_AW +: RAM_AW]),
                .pix_q    (pix_data[n*EW +: EW])
            );
        end
    endgenerate

    always_comb begin
        rd_next = '0;
        if (dec.hit_param) begin
            case (bus_addr)
                8'h03:   rd_next = 32'(PIX_PAR);
                8'h04:   rd_next = 32'(IN_BPS);
                8'h05:   rd_next = 32'(OUT_BPS);
                8'h06:   rd_next = 32'(ALPHA);
                8'h07:   rd_next = 32'(BPC);
                8'h08:   rd_next = 32'(LUT_DIM);
                8'h09:   rd_next = 32'(DBUF != 0);
                default: rd_next = 32'(READBACK != 0);
            endcase
        end else if (dec.hit_ctrl) begin
            rd_next = ctrl_word;
        end else if (dec.hit_win) begin
            for (int n = 0; n < N_RAM; n++)
                if (dec.ram == 6'(n)) rd_next = win_rd[n];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rdata  <= bus_rd ? rd_next : '0;
            bus_rvalid <= bus_rd;
        end
    end
endmodule

// File: rtl/lutcfg_chk.sv
module lutcfg_chk #(
    parameter int N_RAM = 8,
    parameter int EW    = 40,
    parameter int DBUF  = 1
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic        bus_rvalid,
    input logic        frame_start,
    input logic        lut_enable,
    input logic        lut_active_buf
);
    logic       rsv_now;
    logic [7:0] woff;

    assign woff    = bus_addr - 8'h60;
    assign rsv_now = (bus_addr < 8'h03)
                  || (bus_addr > 8'h0A && bus_addr < 8'h52)
                  || (bus_addr > 8'h52 && bus_addr < 8'h60)
                  || (bus_addr >= 8'h60 && int'(woff[7:2]) >= N_RAM)
                  || (bus_addr >= 8'h60 && woff[1:0] == 2'd1)
                  || (bus_addr >= 8'h60 && woff[1:0] == 2'd3 && EW <= 32);

    a_r2_rvalid_follows_rd: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);
    a_r2_no_stray_rvalid: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);
    a_r4_enable_needs_write: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(lut_enable));
    a_r4_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && $past(bus_addr) == 8'h52) |-> bus_rdata[31:2] == 30'b0);
    a_r5_swap_only_at_frame: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(lut_active_buf));
    a_r6_single_buffer_fixed: assert property (@(posedge clk) disable iff (rst)
        (DBUF != 0) || !lut_active_buf);
    a_r11_reserved_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && $past(rsv_now)) |-> bus_rdata == 32'b0);
endmodule

bind lutcfg_regbank lutcfg_chk #(.N_RAM(N_RAM), .EW(EW), .DBUF(DBUF)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .bus_addr       (bus_addr),
    .bus_rdata      (bus_rdata),
    .bus_rvalid     (bus_rvalid),
    .frame_start    (frame_start),
    .lut_enable     (lut_enable),
    .lut_active_buf (lut_active_buf)
);

// File: tb/sim_lutcfg_regbank.sv
module sim_lutcfg_regbank;
    localparam int N = 8, AW = 6, EW0 = 40, EW1 = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        wr [2];
    logic        rd [2];
    logic [7:0]  ad [2];
    logic [31:0] wd [2];
    logic [31:0] rdata [2];
    logic        rv [2];
    logic        en [2];
    logic        act [2];
    logic        fs;
    logic [N*AW-1:0]  pa0, pa1;
    logic [N*EW0-1:0] pd0;
    logic [N*EW1-1:0] pd1;

    lutcfg_regbank u0 (
        .clk(clk), .rst(rst), .bus_wr(wr[0]), .bus_rd(rd[0]), .bus_addr(ad[0]),
        .bus_wdata(wd[0]), .bus_rdata(rdata[0]), .bus_rvalid(rv[0]),
        .frame_start(fs), .lut_enable(en[0]), .lut_active_buf(act[0]),
        .pix_addr(pa0), .pix_data(pd0)
    );

    lutcfg_regbank #(.ALPHA(0), .DBUF(0), .READBACK(0)) u1 (
        .clk(clk), .rst(rst), .bus_wr(wr[1]), .bus_rd(rd[1]), .bus_addr(ad[1]),
        .bus_wdata(wd[1]), .bus_rdata(rdata[1]), .bus_rvalid(rv[1]),
        .frame_start(fs), .lut_enable(en[1]), .lut_active_buf(act[1]),
        .pix_addr(pa1), .pix_data(pd1)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q0[$];
    item_t q1[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic check(string tag, logic [63:0] actual, logic [63:0] expected);
        n_cmp++;
        if (actual !== expected) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
        end
    endtask

    // Monitor: pops expected read words as the design returns them
    always @(negedge clk) begin
        item_t it;
        if (rv[0]) begin
            if (q0.size() == 0) check("R2 u0 stray rvalid", 1, 0);
            else begin it = q0.pop_front(); check(it.tag, rdata[0], it.exp); end
        end
        if (rv[1]) begin
            if (q1.size() == 0) check("R2 u1 stray rvalid", 1, 0);
            else begin it = q1.pop_front(); check(it.tag, rdata[1], it.exp); end
        end
    end

    task automatic wreg(int d, logic [7:0] a, logic [31:0] v);
        @(negedge clk);
        wr[d] = 1'b1; ad[d] = a; wd[d] = v;
        @(negedge clk);
        wr[d] = 1'b0;
    endtask

    task automatic rreg(int d, logic [7:0] a, logic [31:0] exp, string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        @(negedge clk);
        rd[d] = 1'b1; ad[d] = a;
        if (d == 0) q0.push_back(it); else q1.push_back(it);
        @(negedge clk);
        rd[d] = 1'b0;
    endtask

    task automatic frame_pulse();
        @(negedge clk); fs = 1'b1;
        @(negedge clk); fs = 1'b0;
    endtask

    task automatic pix0(int r, logic [AW-1:0] a, logic [EW0-1:0] exp, string tag);
        @(negedge clk); pa0[r*AW +: AW] = a;
        @(negedge clk); check(tag, pd0[r*EW0 +: EW0], exp);
    endtask

    task automatic pix1(int r, logic [AW-1:0] a, logic [EW1-1:0] exp, string tag);
        @(negedge clk); pa1[r*AW +: AW] = a;
        @(negedge clk); check(tag, pd1[r*EW1 +: EW1], exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            wr[d] = 1'b0; rd[d] = 1'b0; ad[d] = '0; wd[d] = '0;
        end
        fs = 1'b0; pa0 = '0; pa1 = '0;
        repeat (3) @(negedge clk);
        check("R1 reset enable", en[0], 0);
        check("R1 reset active buffer", act[0], 0);
        check("R1 reset rvalid", rv[0], 0);
        check("R1 reset rdata", rdata[0], 0);
        rst = 1'b0;
        rreg(0, 8'h52, 32'h0, "R1 control after reset");

        // R3 parameter words
        rreg(0, 8'h03, 2,  "R3 pixels in parallel");
        rreg(0, 8'h04, 10, "R3 input bps");
        rreg(0, 8'h05, 12, "R3 output bps");
        rreg(0, 8'h06, 1,  "R3 alpha");
        rreg(0, 8'h07, 10, "R3 lut depth");
        rreg(0, 8'h08, 17, "R3 lut size");
        rreg(0, 8'h09, 1,  "R3 double buffer flag");
        rreg(0, 8'h0A, 1,  "R3 readback flag");
        rreg(1, 8'h06, 0,  "R3 u1 alpha");
        rreg(1, 8'h09, 0,  "R3 u1 double buffer flag");
        rreg(1, 8'h0A, 0,  "R3 u1 readback flag");

        // Fill copy 1 of RAM 2 while copy 0 is active
        wreg(0, 8'h6A, 32'h89AB_CDEF);
        wreg(0, 8'h6B, 32'h0000_00C3);
        wreg(0, 8'h68, (32'h1 << 28) | 32'd5);
        rreg(0, 8'h68, 32'd5,          "R7 address kept, commit bit cleared");
        rreg(0, 8'h6A, 32'h89AB_CDEF,  "R10 readback lower");
        rreg(0, 8'h6B, 32'h0000_00C3,  "R10 R9 readback upper");

        // Enable and request buffer 1
        wreg(0, 8'h52, 32'hFFFF_FFFF);
        check("R4 enable output", en[0], 1);
        rreg(0, 8'h52, 32'h3, "R4 control readback");
        repeat (3) @(negedge clk);
        check("R5 no swap without frame start", act[0], 0);
        frame_pulse();
        check("R5 swap at frame start", act[0], 1);
        pix0(2, 6'd5, 40'hC3_89AB_CDEF, "R12 R8 new copy seen by pixel path");

        // Write copy 0 while copy 1 is active
        wreg(0, 8'h6A, 32'h1111_2222);
        wreg(0, 8'h6B, 32'h0000_0044);
        wreg(0, 8'h68, (32'h1 << 28) | 32'd5);
        pix0(2, 6'd5, 40'hC3_89AB_CDEF, "R8 active copy untouched");
        rreg(0, 8'h6A, 32'h1111_2222, "R10 readback from inactive copy");
        wreg(0, 8'h52, 32'h1);
        check("R5 request alone keeps buffer", act[0], 1);
        frame_pulse();
        check("R5 swap back", act[0], 0);
        pix0(2, 6'd5, 40'h44_1111_2222, "R12 R8 swapped copy");

        // Last window, top address
        wreg(0, 8'h7E, 32'h0BAD_F00D);
        wreg(0, 8'h7F, 32'h0000_007E);
        wreg(0, 8'h7C, (32'h1 << 28) | 32'd63);
        rreg(0, 8'h7C, 32'd63,         "R7 last window address");
        rreg(0, 8'h7E, 32'h0BAD_F00D,  "R7 last window lower");
        rreg(0, 8'h7F, 32'h0000_007E,  "R7 last window upper");
        wreg(0, 8'h7C, 32'h0001_FFC1);
        rreg(0, 8'h7C, 32'd1,          "R7 high address bits dropped");

        // Reserved space
        wreg(0, 8'h61, 32'hFFFF_FFFF);
        wreg(0, 8'h53, 32'hFFFF_FFFF);
        rreg(0, 8'h00, 0, "R11 low reserved");
        rreg(0, 8'h0B, 0, "R11 after parameters");
        rreg(0, 8'h53, 0, "R11 after control");
        rreg(0, 8'h61, 0, "R11 window reserved slot");
        rreg(0, 8'h80, 0, "R11 beyond last window");
        rreg(0, 8'h52, 32'h1, "R11 control unchanged by reserved writes");

        // Single-buffered, no read-back, narrow entry
        wreg(1, 8'h52, 32'h3);
        rreg(1, 8'h52, 32'h1, "R6 buffer bit reads zero");
        frame_pulse();
        check("R6 active stays zero", act[1], 0);
        wreg(1, 8'h62, 32'h1234_5678);
        wreg(1, 8'h63, 32'h0000_FFFF);
        rreg(1, 8'h63, 32'h0, "R9 absent upper reads zero");
        rreg(1, 8'h62, 32'h1234_5678, "R10 staged value without readback");
        wreg(1, 8'h60, (32'h1 << 28) | 32'd3);
        pix1(0, 6'd3, 30'h1234_5678, "R12 R8 single copy commit");

        repeat (4) @(negedge clk);
        check("R2 all reads answered", 64'(q0.size() + q1.size()), 0);
        finish_run();
    end
endmodule